// File: doc/BRIEF.md
# Audio Source and Channel Router

This block sits in the digital back end of a stereo broadcast sound decoder, between the frame decoder that delivers left and right PCM samples and the reconstruction chain (de-emphasis filter, converters, analog source switches). A three-bit switch code from the control register file picks the audio source driven onto the analog switches: the decoded digital audio, the external line inputs or the FM inputs. For the digital source the same code also picks whether de-emphasis is enabled and what gain the samples get.

When the transmission carries two independent mono programmes instead of a stereo pair, a dual-mono flag and a two-bit selection choose which programme reaches each output, including both-the-same, straight and swapped arrangements. A mute request forces the digital sample data to zero. All control inputs are taken at a sample strobe and the routed samples appear one clock later, so settings never change in the middle of a sample.

Top module: `audio_route_top`

## Requirements
- R1: After synchronous reset, `left_out` and `right_out` are 0, `out_valid` is 0, `src_nicam` is 1 with `src_ext` and `src_fm` 0, `deemph_en` is 1, and the held digital-source setting is de-emphasis on with −6 dB gain (as for switch code 010).
- R2: Switch code 000 selects the digital source (`src_nicam`=1) with `deemph_en`=0 and samples passed unchanged.
- R3: Code 001 gives `deemph_en`=1 with samples unchanged; code 010 gives `deemph_en`=1 with each sample arithmetically shifted right by one bit (−6 dB).
- R4: Code 011 gives `deemph_en`=1 with each sample shifted left by two bits (+12 dB) and saturated to the range −32768..32767.
- R5: A code with bit 2 set selects the external inputs when bit 0 is 0 and the FM inputs when bit 0 is 1, bit 1 being ignored; `deemph_en` and the gain applied to samples stay as set by the last strobed code with bit 2 clear (or by reset).
- R6: With `dual_mono`=1, `left_in` carries programme M1 and `right_in` carries M2, and `dm_sel` (bit 1, bit 0) maps them: 00 gives M2 on both outputs, 01 gives M1 on both, 10 gives M2 left and M1 right, 11 gives M1 left and M2 right.
- R7: With `dual_mono`=0, `dm_sel` has no effect and `left_in`/`right_in` pass to `left_out`/`right_out`.
- R8: A strobe with `mute_req`=1 drives both output samples to 0; the source and de-emphasis outputs still follow the switch code.
- R9: Outputs update only on the clock edge that samples `sample_stb`=1, becoming visible one cycle after the strobe; `out_valid` is high exactly in that cycle, and all outputs hold without a strobe.
- R10: Exactly one of `src_nicam`, `src_ext`, `src_fm` is high at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle strobe marking a new sample pair and control capture |
| left_in | input | 16 | Signed left sample, or programme M1 in dual-mono mode |
| right_in | input | 16 | Signed right sample, or programme M2 in dual-mono mode |
| dual_mono | input | 1 | High when the pair carries two mono programmes |
| dm_sel | input | 2 | Dual-mono output mapping code |
| sw_code | input | 3 | Source, de-emphasis and gain switch code |
| mute_req | input | 1 | High to zero the digital sample data |
| left_out | output | 16 | Routed, scaled left sample |
| right_out | output | 16 | Routed, scaled right sample |
| out_valid | output | 1 | High in the cycle a new output pair is presented |
| deemph_en | output | 1 | Enable for the external de-emphasis filter |
| src_nicam | output | 1 | Analog switch select: decoded digital audio |
| src_ext | output | 1 | Analog switch select: external inputs |
| src_fm | output | 1 | Analog switch select: FM inputs |

## Verification
Every digital switch code is driven with positive, negative and odd-valued samples, so that an arithmetic shift is told apart from a logical one and rounding direction shows on −3; the +12 dB case uses values just inside, on and beyond both saturation limits. Analog codes are strobed after different digital codes and right after reset, with both values of the ignored middle bit, which separates a held setting from a freshly decoded one. Dual-mono mapping uses two distinct programme values under all four selections, and the same selections with the flag low show that stereo passes straight through.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;

    localparam int CODE_W = 3;
    localparam int DMSEL_W = 2;

    typedef enum logic [1:0] {
        SRC_NICAM = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_FM    = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        GAIN_UNITY  = 2'd0,
        GAIN_MINUS6 = 2'd1,
        GAIN_PLUS12 = 2'd2
    } gain_e;

    typedef struct packed {
        logic  deemph;
        gain_e gain;
    } nset_t;

    typedef struct packed {
        src_e  src;
        nset_t set;
    } route_ctl_t;

    // Digital-source setting encoded by the two low code bits.
    function automatic nset_t decode_nset(input logic [1:0] c);
        nset_t s;
        case (c)
            2'b00:   begin s.deemph = 1'b0; s.gain = GAIN_UNITY;  end
            2'b01:   begin s.deemph = 1'b1; s.gain = GAIN_UNITY;  end
            2'b10:   begin s.deemph = 1'b1; s.gain = GAIN_MINUS6; end
            default: begin s.deemph = 1'b1; s.gain = GAIN_PLUS12; end
        endcase
        return s;
    endfunction

    localparam nset_t NSET_RESET = '{deemph: 1'b1, gain: GAIN_MINUS6};

endpackage

// File: rtl/ar_code_decode.sv
module ar_code_decode
    import audio_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [CODE_W-1:0] code,
    output route_ctl_t        ctl
);

    nset_t set_q;
    nset_t set_eff;

    always_comb begin
        if (code[2]) begin
            set_eff = set_q;
            ctl.src = code[0] ? SRC_FM : SRC_EXT;
        end else begin
            set_eff = decode_nset(code[1:0]);
            ctl.src = SRC_NICAM;
        end
        ctl.set = set_eff;
    end

    always_ff @(posedge clk) begin
        if (rst)
            set_q <= NSET_RESET;
        else if (stb)
            set_q <= set_eff;
    end

    // R5
    held_setting_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && code[2]) |=> $stable(set_q));

endmodule

// File: rtl/ar_chan_map.sv
module ar_chan_map
    import audio_route_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                dual_mono,
    input  logic [DMSEL_W-1:0]  dm_sel,
    input  logic signed [W-1:0] m1,
    input  logic signed [W-1:0] m2,
    output logic signed [W-1:0] l_out,
    output logic signed [W-1:0] r_out
);

    always_comb begin
        if (!dual_mono) begin
            l_out = m1;
            r_out = m2;
        end else begin
            l_out = dm_sel[0] ? m1 : m2;
            case (dm_sel)
                2'b00:   r_out = m2;
                2'b01:   r_out = m1;
                2'b10:   r_out = m1;
                default: r_out = m2;
            endcase
        end
    end

endmodule

// File: rtl/ar_gain_stage.sv
module ar_gain_stage
    import audio_route_pkg::*;
#(
    parameter int W = 16
) (
    input  gain_e               gain,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);

    localparam int WX = W + 2;
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [WX-1:0] boosted;
    logic                 ovf;

    always_comb begin
        boosted = {{2{din[W-1]}}, din} <<< 2;
        ovf     = (boosted[WX-1:W-1] != {3{boosted[WX-1]}});
        case (gain)
            GAIN_MINUS6: dout = din >>> 1;
            GAIN_PLUS12: begin
                if (ovf)
                    dout = boosted[WX-1] ? MIN_V : MAX_V;
                else
                    dout = boosted[W-1:0];
            end
            default:     dout = din;
        endcase
    end

endmodule

// File: rtl/audio_route_top.sv
module audio_route_top
    import audio_route_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_stb,
    input  logic signed [SAMPLE_W-1:0] left_in,
    input  logic signed [SAMPLE_W-1:0] right_in,
    input  logic                       dual_mono,
    input  logic [1:0]                 dm_sel,
    input  logic [2:0]                 sw_code,
    input  logic                       mute_req,
    output logic signed [SAMPLE_W-1:0] left_out,
    output logic signed [SAMPLE_W-1:0] right_out,
    output logic                       out_valid,
    output logic                       deemph_en,
    output logic                       src_nicam,
    output logic                       src_ext,
    output logic                       src_fm
);

    localparam int NCH = 2;

    route_ctl_t ctl;
    src_e       src_q;
    logic signed [SAMPLE_W-1:0] mapped [NCH];
    logic signed [SAMPLE_W-1:0] scaled [NCH];

    ar_code_decode u_dec (
        .clk  (clk),
        .rst  (rst),
        .stb  (sample_stb),
        .code (sw_code),
        .ctl  (ctl)
    );

    ar_chan_map #(.W(SAMPLE_W)) u_map (
        .dual_mono (dual_mono),
        .dm_sel    (dm_sel),
        .m1        (left_in),
        .m2        (right_in),
        .l_out     (mapped[0]),
        .r_out     (mapped[1])
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_gain
        ar_gain_stage #(.W(SAMPLE_W)) u_gain (
            .gain (ctl.set.gain),
            .din  (mapped[ch]),
            .dout (scaled[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_out  <= '0;
            right_out <= '0;
            out_valid <= 1'b0;
            deemph_en <= NSET_RESET.deemph;
            src_q     <= SRC_NICAM;
        end else begin
            out_valid <= sample_stb;
            if (sample_stb) begin
                left_out  <= mute_req ? '0 : scaled[0];
                right_out <= mute_req ? '0 : scaled[1];
                deemph_en <= ctl.set.deemph;
                src_q     <= ctl.src;
            end
        end
    end

    assign src_nicam = (src_q == SRC_NICAM);
    assign src_ext   = (src_q == SRC_EXT);
    assign src_fm    = (src_q == SRC_FM);

    // R10
    src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({src_nicam, src_ext, src_fm}) == 1);

    // R8
    mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && mute_req) |=> (left_out == '0 && right_out == '0));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> out_valid);

    // R9
    hold_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> (!out_valid && $stable(left_out) && $stable(right_out)
                         && $stable(deemph_en) && $stable(src_q)));

    // R2
    flat_code_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && sw_code == 3'b000) |=> (!deemph_en && src_nicam));

    // R5
    fm_select_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && sw_code[2] && sw_code[0]) |=> src_fm);

endmodule

// File: tb/audio_route_top_tb_top.sv
module audio_route_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_stb = 1'b0;
    logic signed [15:0] left_in = '0;
    logic signed [15:0] right_in = '0;
    logic dual_mono = 1'b0;
    logic [1:0] dm_sel = 2'b10;
    logic [2:0] sw_code = 3'b010;
    logic mute_req = 1'b0;
    logic signed [15:0] left_out, right_out;
    logic out_valid, deemph_en, src_nicam, src_ext, src_fm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audio_route_top dut_i (
        .clk(clk), .rst(rst), .sample_stb(sample_stb),
        .left_in(left_in), .right_in(right_in),
        .dual_mono(dual_mono), .dm_sel(dm_sel), .sw_code(sw_code),
        .mute_req(mute_req),
        .left_out(left_out), .right_out(right_out), .out_valid(out_valid),
        .deemph_en(deemph_en), .src_nicam(src_nicam), .src_ext(src_ext),
        .src_fm(src_fm)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference scaling from the requirements: 0 unity, 1 half, 2 times four saturated.
    function automatic int scale(input int x, input int g);
        int y;
        if (g == 1) y = (x >= 0) ? x / 2 : -((-x + 1) / 2);
        else if (g == 2) begin
            y = x * 4;
            if (y > 32767) y = 32767;
            if (y < -32768) y = -32768;
        end else y = x;
        return y;
    endfunction

    // Present one strobed sample; outputs are checked in the following cycle.
    task automatic strobe(input int l, input int r, input bit dm, input logic [1:0] sel,
                          input logic [2:0] code, input bit mute);
        @(negedge clk);
        left_in = 16'(l); right_in = 16'(r);
        dual_mono = dm; dm_sel = sel; sw_code = code; mute_req = mute;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic expect_out(input string req, input int l, input int r, input int de,
                              input int n, input int e, input int f);
        chk(req, "left_out", int'(left_out), l);
        chk(req, "right_out", int'(right_out), r);
        chk(req, "deemph_en", int'(deemph_en), de);
        chk(req, "src_nicam", int'(src_nicam), n);
        chk(req, "src_ext", int'(src_ext), e);
        chk(req, "src_fm", int'(src_fm), f);
        chk("R9", "out_valid", int'(out_valid), 1);
    endtask

    task automatic t_reset_state();
        chk("R1", "left_out", int'(left_out), 0);
        chk("R1", "right_out", int'(right_out), 0);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "src_nicam", int'(src_nicam), 1);
        chk("R1", "src_ext", int'(src_ext), 0);
        chk("R1", "deemph_en", int'(deemph_en), 1);
        // analog code straight after reset keeps the -6 dB reset setting
        strobe(100, -101, 0, 2'b10, 3'b100, 0);
        expect_out("R1", 50, scale(-101, 1), 1, 0, 1, 0);
    endtask

    task automatic t_digital_codes();
        strobe(1000, -3000, 0, 2'b10, 3'b000, 0);
        expect_out("R2", 1000, -3000, 0, 1, 0, 0);
        strobe(-77, 4321, 0, 2'b10, 3'b001, 0);
        expect_out("R3", -77, 4321, 1, 1, 0, 0);
        strobe(-3, 1001, 0, 2'b10, 3'b010, 0);
        expect_out("R3", -2, 500, 1, 1, 0, 0);
        strobe(5000, 9000, 0, 2'b10, 3'b011, 0);
        expect_out("R4", 20000, 32767, 1, 1, 0, 0);
        strobe(-8192, -9000, 0, 2'b10, 3'b011, 0);
        expect_out("R4", -32768, -32768, 1, 1, 0, 0);
        strobe(8191, 8192, 0, 2'b10, 3'b011, 0);
        expect_out("R4", 32764, 32767, 1, 1, 0, 0);
    endtask

    task automatic t_analog_hold();
        strobe(100, -100, 0, 2'b10, 3'b011, 0);
        strobe(100, -100, 0, 2'b10, 3'b110, 0);
        expect_out("R5", 400, -400, 1, 0, 1, 0);
        strobe(100, -100, 0, 2'b10, 3'b101, 0);
        expect_out("R5", 400, -400, 1, 0, 0, 1);
        strobe(7, 8, 0, 2'b10, 3'b000, 0);
        strobe(7, 8, 0, 2'b10, 3'b111, 0);
        expect_out("R5", 7, 8, 0, 0, 0, 1);
        strobe(7, 8, 0, 2'b10, 3'b100, 0);
        expect_out("R5", 7, 8, 0, 0, 1, 0);
    endtask

    task automatic t_dual_mono();
        strobe(111, 222, 1, 2'b00, 3'b000, 0);
        expect_out("R6", 222, 222, 0, 1, 0, 0);
        strobe(111, 222, 1, 2'b01, 3'b000, 0);
        expect_out("R6", 111, 111, 0, 1, 0, 0);
        strobe(111, 222, 1, 2'b10, 3'b000, 0);
        expect_out("R6", 222, 111, 0, 1, 0, 0);
        strobe(111, 222, 1, 2'b11, 3'b000, 0);
        expect_out("R6", 111, 222, 0, 1, 0, 0);
        for (int s = 0; s < 4; s++) begin
            strobe(-333, 444, 0, 2'(s), 3'b000, 0);
            expect_out("R7", -333, 444, 0, 1, 0, 0);
        end
    endtask

    task automatic t_mute();
        strobe(1234, -1234, 0, 2'b10, 3'b001, 1);
        expect_out("R8", 0, 0, 1, 1, 0, 0);
        strobe(1234, -1234, 1, 2'b11, 3'b101, 1);
        expect_out("R8", 0, 0, 1, 0, 0, 1);
    endtask

    task automatic t_hold();
        strobe(600, 700, 0, 2'b10, 3'b000, 0);
        expect_out("R9", 600, 700, 0, 1, 0, 0);
        @(negedge clk);
        left_in = 16'sd9; right_in = -16'sd9; sw_code = 3'b011; mute_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "valid low", int'(out_valid), 0);
        chk("R9", "left held", int'(left_out), 600);
        chk("R9", "right held", int'(right_out), 700);
        chk("R9", "deemph held", int'(deemph_en), 0);
        chk("R10", "src held", int'(src_nicam), 1);
        mute_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_digital_codes();
        t_analog_hold();
        t_dual_mono();
        t_mute();
        t_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule